// File: doc/BRIEF.md
# Digital Stereo/Mono Mixer Router

This block is a sample-domain model of an audio output mixer. Each time the sample strobe is high it takes one signed left, right and mono sample, scales each by a stepped gain chosen by a 5-bit code, and combines and routes the scaled terms to four outputs. The four outputs are a loudspeaker pair and a headphone pair. A 4-bit mode code chooses which terms reach each output pair, and whether each pair is on, muted or shut down. Loudspeaker outputs carry twice the headphone level.

Each output pair has its own wake-up counter. When a pair leaves shutdown, it drives silence for a set number of sample strobes before the signal appears. A select input chooses the short or the long delay. Gains are unsigned Q2.14 multipliers. The gain code steps by a factor of 2^(1/4), about 1.5 dB per step. Every sum saturates to the 16-bit signed range instead of wrapping.

Top module: `mix_router`

## Requirements
- R1: While rst_ni is low, and after it is released, all four sample outputs are zero and all bits of active_o are low.
- R2: Outputs and active_o change only at a rising clock edge where smp_valid_i is high. They hold their values while smp_valid_i is low.
- R3: Stereo gain code c gives multiplier G = min(65535, floor(F[m mod 4] * 2^(m div 4) / 128)), where m = c + 1 and F = {16384, 19484, 23170, 27554}. Code 27 gives 16384 (unity) and code 31 gives 32768.
- R4: Mono gain code c uses the same formula with m = c + 5. Code 23 gives 16384 (unity) and code 31 saturates to 65535.
- R5: Each term is floor(x * G / 16384). A headphone output is the sum of its selected terms, and a loudspeaker output is twice that sum.
- R6: Mode codes 0, 1, 5, 6, 10, 11 and 15 shut down all four outputs.
- R7: Mode 2 puts the mono term on both loudspeakers and mutes the headphones. Mode 3 also puts the mono term on both headphones. Mode 4 shuts the loudspeakers and keeps mono on the headphones.
- R8: Mode 7 puts the left term on the left loudspeaker and the right term on the right loudspeaker, and mutes the headphones. Mode 8 also drives the headphones left and right. Mode 9 shuts the loudspeakers and keeps stereo on the headphones.
- R9: Modes 12, 13 and 14 route outputs as modes 7, 8 and 9 do, but each active output carries its stereo term plus the mono term.
- R10: A muted output is zero with its active bit high. A shut-down output is zero with its active bit low. The active_o bit order is: bit 0 loudspeaker left, bit 1 loudspeaker right, bit 2 headphone left, bit 3 headphone right.
- R11: When an output pair goes from shutdown to muted or on (reset counts as shutdown), its outputs are zero for the next WAKE_FAST strobes if slow_wake_i is 0, or WAKE_SLOW strobes if it is 1. The active bits are high during this time, and slow_wake_i is taken at the strobe that leaves shutdown. A pair that stays out of shutdown is never delayed again. Defaults are 4096 and 8192.
- R12: Results above 32767 become 32767, and results below -32768 become -32768.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| smp_valid_i | input | 1 | Sample strobe |
| left_i | input | 16 | Left sample, signed |
| right_i | input | 16 | Right sample, signed |
| mono_i | input | 16 | Mono sample, signed |
| gain_l_i | input | 5 | Left stereo gain code |
| gain_r_i | input | 5 | Right stereo gain code |
| gain_m_i | input | 5 | Mono gain code |
| mode_i | input | 4 | Mix and route mode |
| slow_wake_i | input | 1 | Selects the long wake-up delay |
| spk_l_o | output | 16 | Loudspeaker left sample |
| spk_r_o | output | 16 | Loudspeaker right sample |
| hp_l_o | output | 16 | Headphone left sample |
| hp_r_o | output | 16 | Headphone right sample |
| active_o | output | 4 | Per-output active flags |

## Verification
The bench counts the silent strobes after each exit from shutdown, in both the short and the long setting. A timer that is off by one would leak a sample early or keep silence one strobe too long. It also moves only one output pair out of shutdown, so that a timer shared between the pairs would wrongly silence the headphones. Full-scale samples at the largest mono gain, and negative samples at the smallest gain, catch a design that wraps instead of saturating or rounds toward zero instead of flooring. The bench also checks that reserved mode codes and mute differ only in the active flags.

// File: rtl/mix_pkg.sv
package mix_pkg;
  localparam int SMP_W  = 16;
  localparam int GAIN_W = 16;
  localparam int CODE_W = 5;
  localparam int MODE_W = 4;
  localparam int FRAC_W = 14;
  localparam int TERM_W = SMP_W + 2;
  localparam int SUM_W  = TERM_W + 1;
  localparam int WIDE_W = SUM_W + 1;
  localparam int N_OUT  = 4;
  localparam int N_GRP  = 2;

  typedef enum logic [1:0] {
    GRP_SHUT = 2'd0,
    GRP_MUTE = 2'd1,
    GRP_ON   = 2'd2
  } grp_state_e;

  typedef struct packed {
    grp_state_e state;
    logic       use_st;
    logic       use_mono;
  } grp_ctl_t;

  function automatic logic signed [SMP_W-1:0] sat_smp(input logic signed [WIDE_W-1:0] v);
    if (v > WIDE_W'(32767))       return 16'sh7fff;
    else if (v < -WIDE_W'(32768)) return 16'sh8000;
    else                          return v[SMP_W-1:0];
  endfunction
endpackage

// File: rtl/mix_gain_lut.sv
module mix_gain_lut
  import mix_pkg::*;
#(
  parameter int ZERO_CODE = 27
) (
  input  logic [CODE_W-1:0] code_i,
  output logic [GAIN_W-1:0] gain_o
);
  // offset keeps the step index non-negative; 7 octaves below unity fit the range
  localparam int OFS   = 28 - ZERO_CODE;
  localparam int DOWN  = 7;
  localparam int WIDE  = 32;

  logic [14:0]     frac;
  logic [WIDE-1:0] wide;
  logic [6:0]      step;

  always_comb begin
    step = 7'(int'(code_i) + OFS);
    case (step[1:0])
      2'd0:    frac = 15'd16384;
      2'd1:    frac = 15'd19484;
      2'd2:    frac = 15'd23170;
      default: frac = 15'd27554;
    endcase
    wide = (WIDE'(frac) << step[6:2]) >> DOWN;
    if (wide > WIDE'(65535)) gain_o = 16'hffff;
    else                     gain_o = wide[GAIN_W-1:0];
    // R3 / R4: the zero code is exact unity
    if (code_i == CODE_W'(ZERO_CODE))
      p_unity_r3: assert (gain_o == 16'd16384);
  end
endmodule

// File: rtl/mix_mode_decode.sv
module mix_mode_decode
  import mix_pkg::*;
(
  input  logic [MODE_W-1:0] mode_i,
  output grp_ctl_t          spk_o,
  output grp_ctl_t          hp_o
);
  always_comb begin
    spk_o = '{state: GRP_SHUT, use_st: 1'b0, use_mono: 1'b0};
    hp_o  = '{state: GRP_SHUT, use_st: 1'b0, use_mono: 1'b0};
    case (mode_i)
      4'd2:  begin spk_o = '{GRP_ON, 1'b0, 1'b1}; hp_o = '{GRP_MUTE, 1'b0, 1'b0}; end
      4'd3:  begin spk_o = '{GRP_ON, 1'b0, 1'b1}; hp_o = '{GRP_ON,   1'b0, 1'b1}; end
      4'd4:  begin                                hp_o = '{GRP_ON,   1'b0, 1'b1}; end
      4'd7:  begin spk_o = '{GRP_ON, 1'b1, 1'b0}; hp_o = '{GRP_MUTE, 1'b0, 1'b0}; end
      4'd8:  begin spk_o = '{GRP_ON, 1'b1, 1'b0}; hp_o = '{GRP_ON,   1'b1, 1'b0}; end
      4'd9:  begin                                hp_o = '{GRP_ON,   1'b1, 1'b0}; end
      4'd12: begin spk_o = '{GRP_ON, 1'b1, 1'b1}; hp_o = '{GRP_MUTE, 1'b0, 1'b0}; end
      4'd13: begin spk_o = '{GRP_ON, 1'b1, 1'b1}; hp_o = '{GRP_ON,   1'b1, 1'b1}; end
      4'd14: begin                                hp_o = '{GRP_ON,   1'b1, 1'b1}; end
      default: ;
    endcase
    // R6: reserved codes and code 6 leave every output shut
    if (mode_i inside {4'd0, 4'd1, 4'd5, 4'd6, 4'd10, 4'd11, 4'd15})
      p_rsvd_shut_r6: assert (spk_o.state == GRP_SHUT && hp_o.state == GRP_SHUT);
  end
endmodule

// File: rtl/mix_wake_timer.sv
module mix_wake_timer #(
  parameter int WAKE_FAST = 4096,
  parameter int WAKE_SLOW = 8192
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic strobe_i,
  input  logic shut_i,
  input  logic slow_i,
  output logic hold_o
);
  localparam int CNT_W = $clog2(WAKE_SLOW + 1);

  logic             prev_shut_q;
  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] remain;

  // remain = silent strobes still owed, counting the current one
  always_comb begin
    if (prev_shut_q) remain = slow_i ? CNT_W'(WAKE_SLOW) : CNT_W'(WAKE_FAST);
    else             remain = cnt_q;
    hold_o = (remain != '0);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      prev_shut_q <= 1'b1;
      cnt_q       <= '0;
    end else if (strobe_i) begin
      prev_shut_q <= shut_i;
      if (shut_i || remain == '0) cnt_q <= '0;
      else                        cnt_q <= remain - 1'b1;
    end
  end

  p_wake_cap_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= CNT_W'(WAKE_SLOW));

  p_wake_entry_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (strobe_i && prev_shut_q && !shut_i) |-> hold_o);
endmodule

// File: rtl/mix_router.sv
module mix_router
  import mix_pkg::*;
#(
  parameter int WAKE_FAST   = 4096,
  parameter int WAKE_SLOW   = 8192,
  parameter int STEREO_ZERO = 27,
  parameter int MONO_ZERO   = 23
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    smp_valid_i,
  input  logic signed [SMP_W-1:0] left_i,
  input  logic signed [SMP_W-1:0] right_i,
  input  logic signed [SMP_W-1:0] mono_i,
  input  logic [CODE_W-1:0]       gain_l_i,
  input  logic [CODE_W-1:0]       gain_r_i,
  input  logic [CODE_W-1:0]       gain_m_i,
  input  logic [MODE_W-1:0]       mode_i,
  input  logic                    slow_wake_i,
  output logic signed [SMP_W-1:0] spk_l_o,
  output logic signed [SMP_W-1:0] spk_r_o,
  output logic signed [SMP_W-1:0] hp_l_o,
  output logic signed [SMP_W-1:0] hp_r_o,
  output logic [N_OUT-1:0]        active_o
);
  localparam int N_CH  = 3;
  localparam int PROD_W = SMP_W + GAIN_W + 1;

  logic [CODE_W-1:0]        code  [N_CH];
  logic signed [SMP_W-1:0]  smp   [N_CH];
  logic [GAIN_W-1:0]        gain  [N_CH];
  logic signed [TERM_W-1:0] term  [N_CH];
  grp_ctl_t                 ctl   [N_GRP];
  logic [N_GRP-1:0]         hold;
  logic signed [SMP_W-1:0]  out_q [N_OUT];
  logic [N_OUT-1:0]         act_q;

  assign code[0] = gain_l_i;
  assign code[1] = gain_r_i;
  assign code[2] = gain_m_i;
  assign smp[0]  = left_i;
  assign smp[1]  = right_i;
  assign smp[2]  = mono_i;

  for (genvar c = 0; c < N_CH; c++) begin : g_ch
    localparam int ZC = (c == N_CH - 1) ? MONO_ZERO : STEREO_ZERO;
    logic signed [PROD_W-1:0] prod;

    mix_gain_lut #(.ZERO_CODE(ZC)) u_lut (
      .code_i (code[c]),
      .gain_o (gain[c])
    );

    assign prod    = PROD_W'(smp[c]) * $signed({1'b0, gain[c]});
    // floor division by 2^14 via the arithmetic bit slice
    assign term[c] = prod[FRAC_W +: TERM_W];
  end

  mix_mode_decode u_dec (
    .mode_i (mode_i),
    .spk_o  (ctl[0]),
    .hp_o   (ctl[1])
  );

  for (genvar g = 0; g < N_GRP; g++) begin : g_wake
    mix_wake_timer #(.WAKE_FAST(WAKE_FAST), .WAKE_SLOW(WAKE_SLOW)) u_wake (
      .clk_i    (clk_i),
      .rst_ni   (rst_ni),
      .strobe_i (smp_valid_i),
      .shut_i   (ctl[g].state == GRP_SHUT),
      .slow_i   (slow_wake_i),
      .hold_o   (hold[g])
    );
  end

  for (genvar i = 0; i < N_OUT; i++) begin : g_out
    localparam int GRP  = i / 2;
    localparam int SIDE = i % 2;
    logic signed [SUM_W-1:0]  sum;
    logic signed [WIDE_W-1:0] scaled;
    logic signed [SMP_W-1:0]  nxt;

    always_comb begin
      sum = '0;
      if (ctl[GRP].use_st)   sum = sum + SUM_W'(term[SIDE]);
      if (ctl[GRP].use_mono) sum = sum + SUM_W'(term[N_CH-1]);
      scaled = (GRP == 0) ? (WIDE_W'(sum) <<< 1) : WIDE_W'(sum);
      nxt    = (ctl[GRP].state == GRP_ON && !hold[GRP]) ? sat_smp(scaled) : '0;
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        out_q[i] <= '0;
        act_q[i] <= 1'b0;
      end else if (smp_valid_i) begin
        out_q[i] <= nxt;
        act_q[i] <= (ctl[GRP].state != GRP_SHUT);
      end
    end

    p_shut_quiet_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !act_q[i] |-> out_q[i] == '0);

    p_wake_zero_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $rose(act_q[i]) |-> out_q[i] == '0);

    p_hold_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !$past(smp_valid_i) |-> ($stable(out_q[i]) && $stable(act_q[i])));
  end

  assign spk_l_o  = out_q[0];
  assign spk_r_o  = out_q[1];
  assign hp_l_o   = out_q[2];
  assign hp_r_o   = out_q[3];
  assign active_o = act_q;
endmodule

// File: tb/sim_mix_router.sv
module sim_mix_router;
  localparam int FAST = 16;
  localparam int SLOW = 32;

  typedef struct packed {
    logic [3:0]         mode;
    logic [4:0]         gl, gr, gm;
    logic signed [15:0] l, r, m;
  } vec_t;

  localparam int NV = 10;
  localparam vec_t VECS [NV] = '{
    '{4'd13, 5'd27, 5'd27, 5'd23, 16'sd1000,  -16'sd2000,  16'sd500},
    '{4'd8,  5'd31, 5'd0,  5'd23, 16'sd1000,  16'sd1000,   16'sd0},
    '{4'd3,  5'd27, 5'd27, 5'd31, 16'sd0,     16'sd0,      -16'sd32768},
    '{4'd2,  5'd27, 5'd27, 5'd31, 16'sd0,     16'sd0,      16'sd32767},
    '{4'd7,  5'd20, 5'd30, 5'd0,  -16'sd1234, 16'sd4321,   16'sd9999},
    '{4'd12, 5'd27, 5'd27, 5'd23, 16'sd20000, -16'sd20000, 16'sd15000},
    '{4'd13, 5'd10, 5'd15, 5'd5,  16'sd32767, -16'sd32768, -16'sd100},
    '{4'd8,  5'd0,  5'd0,  5'd0,  -16'sd1,    -16'sd1,     -16'sd1},
    '{4'd3,  5'd0,  5'd0,  5'd0,  16'sd32767, 16'sd32767,  16'sd32767},
    '{4'd13, 5'd31, 5'd31, 5'd31, 16'sd32767, 16'sd32767,  16'sd32767}
  };

  logic clk = 1'b0, rst_n = 1'b0, valid = 1'b0, slow = 1'b0;
  logic signed [15:0] l = '0, r = '0, m = '0;
  logic [4:0] gl = '0, gr = '0, gm = '0;
  logic [3:0] mode = '0;
  logic signed [15:0] spk_l, spk_r, hp_l, hp_r;
  logic [3:0] act;

  int checks = 0, fails = 0;
  int exp_o [4];
  logic [3:0] exp_act;

  always #10 clk = ~clk;

  mix_router #(.WAKE_FAST(FAST), .WAKE_SLOW(SLOW)) u0 (
    .clk_i(clk), .rst_ni(rst_n), .smp_valid_i(valid),
    .left_i(l), .right_i(r), .mono_i(m),
    .gain_l_i(gl), .gain_r_i(gr), .gain_m_i(gm),
    .mode_i(mode), .slow_wake_i(slow),
    .spk_l_o(spk_l), .spk_r_o(spk_r), .hp_l_o(hp_l), .hp_r_o(hp_r),
    .active_o(act)
  );

  function automatic longint gain_of(int code, int zero);
    int s = code + 28 - zero;
    longint f = longint'($rtoi(16384.0 * (2.0 ** ((s % 4) / 4.0)) + 0.5));
    longint g = (f << (s / 4)) >> 7;
    return (g > 65535) ? 65535 : g;
  endfunction

  function automatic longint term(int x, longint g);
    longint p = longint'(x) * g;
    return p >>> 14;
  endfunction

  function automatic int sat(longint v);
    if (v > 32767) return 32767;
    if (v < -32768) return -32768;
    return int'(v);
  endfunction

  // state 0 shut, 1 mute, 2 on
  task automatic model(input logic spk_hold, input logic hp_hold);
    int ss = 0, hs = 0;
    bit sst = 0, smo = 0, hst = 0, hmo = 0;
    longint tl, tr, tm;
    case (mode)
      4'd2:  begin ss = 2; smo = 1; hs = 1; end
      4'd3:  begin ss = 2; smo = 1; hs = 2; hmo = 1; end
      4'd4:  begin hs = 2; hmo = 1; end
      4'd7:  begin ss = 2; sst = 1; hs = 1; end
      4'd8:  begin ss = 2; sst = 1; hs = 2; hst = 1; end
      4'd9:  begin hs = 2; hst = 1; end
      4'd12: begin ss = 2; sst = 1; smo = 1; hs = 1; end
      4'd13: begin ss = 2; sst = 1; smo = 1; hs = 2; hst = 1; hmo = 1; end
      4'd14: begin hs = 2; hst = 1; hmo = 1; end
      default: ;
    endcase
    tl = term(int'(l), gain_of(gl, 27));
    tr = term(int'(r), gain_of(gr, 27));
    tm = term(int'(m), gain_of(gm, 23));
    exp_o[0] = (ss == 2 && !spk_hold) ? sat(2 * ((sst ? tl : 0) + (smo ? tm : 0))) : 0;
    exp_o[1] = (ss == 2 && !spk_hold) ? sat(2 * ((sst ? tr : 0) + (smo ? tm : 0))) : 0;
    exp_o[2] = (hs == 2 && !hp_hold) ? sat((hst ? tl : 0) + (hmo ? tm : 0)) : 0;
    exp_o[3] = (hs == 2 && !hp_hold) ? sat((hst ? tr : 0) + (hmo ? tm : 0)) : 0;
    exp_act = {(hs != 0), (hs != 0), (ss != 0), (ss != 0)};
  endtask

  task automatic chk(input string req, input string what, input int got, input int want);
    checks++;
    if (got != want) begin
      fails++;
      $display("FAIL %s %s: got %0d expected %0d", req, what, got, want);
    end
  endtask

  task automatic check_all(input string req, input logic sh, input logic hh);
    model(sh, hh);
    chk(req, "spk_l", int'(spk_l), exp_o[0]);
    chk(req, "spk_r", int'(spk_r), exp_o[1]);
    chk(req, "hp_l",  int'(hp_l),  exp_o[2]);
    chk(req, "hp_r",  int'(hp_r),  exp_o[3]);
    chk(req, "active", int'(act), int'(exp_act));
  endtask

  task automatic strobe();
    @(negedge clk) valid = 1'b1;
    @(negedge clk) valid = 1'b0;
  endtask

  initial begin
    #3000000;
    fails++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    int sv_spk;
    gl = 5'd27; gr = 5'd27; gm = 5'd23; l = 16'sd100; r = 16'sd200; m = 16'sd300;
    repeat (3) @(negedge clk);
    // R1: outputs under reset
    check_all("R1", 1'b0, 1'b0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    check_all("R1", 1'b0, 1'b0);

    // R11: leaving reset into mode 13 holds both pairs silent for FAST strobes
    mode = 4'd13;
    for (int k = 0; k < FAST; k++) begin
      strobe();
      check_all("R11", 1'b1, 1'b1);
    end
    strobe();
    check_all("R11", 1'b0, 1'b0);

    // R3 R4 R5 R7 R8 R9 R12: vector walk, both pairs stay out of shutdown
    for (int v = 0; v < NV; v++) begin
      mode = VECS[v].mode; gl = VECS[v].gl; gr = VECS[v].gr; gm = VECS[v].gm;
      l = VECS[v].l; r = VECS[v].r; m = VECS[v].m;
      strobe();
      check_all("R5/R12 vec", 1'b0, 1'b0);
    end

    // R2: inputs change without a strobe, outputs must hold
    sv_spk = int'(spk_l);
    l = 16'sd7; m = -16'sd7; mode = 4'd0;
    repeat (5) @(negedge clk);
    chk("R2", "spk_l held", int'(spk_l), sv_spk);
    chk("R2", "active held", int'(act), 4'hf);

    // R8 R10: mode 9 shuts loudspeakers, headphones stay live with no delay
    mode = 4'd9; gl = 5'd27; gr = 5'd27; gm = 5'd23;
    l = 16'sd1500; r = -16'sd2500; m = 16'sd400;
    strobe();
    check_all("R8", 1'b0, 1'b0);
    // R9: mode 14 mixes on headphones
    mode = 4'd14;
    strobe();
    check_all("R9", 1'b0, 1'b0);
    // R11: loudspeakers re-enter, only they are delayed
    mode = 4'd13;
    strobe();
    check_all("R11 spk", 1'b1, 1'b0);
    for (int k = 1; k < FAST; k++) strobe();
    check_all("R11 spk", 1'b1, 1'b0);
    strobe();
    check_all("R11 spk", 1'b0, 1'b0);

    // R10: mute vs shut flags
    mode = 4'd7;
    strobe();
    check_all("R10", 1'b0, 1'b0);
    mode = 4'd4;
    strobe();
    check_all("R7", 1'b0, 1'b0);

    // R6: shut and reserved codes
    foreach (VECS[i]) ;
    for (int k = 0; k < 16; k++) begin
      if (k inside {0, 1, 5, 6, 10, 11, 15}) begin
        mode = 4'(k);
        strobe();
        check_all("R6", 1'b0, 1'b0);
      end
    end

    // R11: long setting
    slow = 1'b1; mode = 4'd8;
    for (int k = 0; k < SLOW; k++) begin
      strobe();
      if (k == FAST || k == SLOW - 1) check_all("R11 slow", 1'b1, 1'b1);
    end
    slow = 1'b0;
    strobe();
    check_all("R11 slow", 1'b0, 1'b0);

    // R1: reset mid-run clears everything
    rst_n = 1'b0;
    @(negedge clk);
    mode = 4'd0;
    check_all("R1", 1'b0, 1'b0);
    rst_n = 1'b1;

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule